// File: doc/BRIEF.md
# Converter Serial Result Shifter

This block is the device-side serial output stage of a delta-sigma converter. A stand-in conversion engine, modelled as a counter of programmable latency, captures a signed result, a set of sub-LSB bits and a sign flag when it completes. The shifter then presents them on a single data line under the control of a chip-select and a serial clock, both driven by an external host. While the host deselects the block, the data line is released (its output enable is low). When the block is selected but no frame has been latched, the line carries a live busy flag. That flag lets the host use the line as a completion interrupt.

A frame is `FRAME_W = 3 + RES_W + SUB_W` bits long, which is 32 with the default widths. It starts with the end-of-conversion bit, followed by a zero dummy bit, the sign bit, the result MSB first and finally the sub-LSB bits. Each falling serial-clock edge advances the line by one bit. After the whole frame has been shifted, the line rests high. Deselecting the block at any point after a frame has been latched starts a new conversion, whether the read was complete or aborted. Chip-select and the serial clock are assumed to be synchronous to `clk`; the serial clock's falling edge is detected on `clk`.

Top module: `ser_result_out`

## Requirements
- R1: The frame is FRAME_W bits, sent from bit FRAME_W-1 down to bit 0. The bits are, in order: end-of-conversion (0 in a latched frame), a dummy bit that is always 0, the sign, the RES_W-bit code MSB first, and the SUB_W sub-LSB bits.
- R2: `sdo_oe` is 1 exactly while `cs_n` is 0, and it changes in the same cycle as `cs_n`.
- R3: While `cs_n` is 0 and no frame is latched, `sdo` shows the conversion state with no clock delay: 1 while converting, 0 once a result is ready. It drops to 0 in the cycle the conversion completes.
- R4: A conversion stays busy for exactly CONV_CYCLES clock cycles after the restart edge. The inputs `in_sign`, `in_code` and `in_sub` are captured when the conversion completes, and later changes to them do not alter the frame.
- R5: With `cs_n` low and a result ready, the frame is latched at the next clock edge. The first bit on `sdo` is then bit FRAME_W-1, which is 0.
- R6: Each falling edge of `sck` seen by `clk` advances `sdo` by one bit. After FRAME_W-1 falls, `sdo` shows bit 0.
- R7: On the FRAME_W-th falling edge `sdo` goes to 1, and it stays 1 through any further edges until `cs_n` rises.
- R8: `sck` edges while `cs_n` is 1, or while no frame is latched, do not move the shift register: the next read still starts at bit FRAME_W-1.
- R9: A rise of `cs_n` after a frame has been latched starts a new conversion, whether after a partial read (abort) or a complete read.
- R10: A `cs_n` low pulse during a conversion, with no frame latched, does not restart the conversion: the result becomes ready on the original schedule.
- R11: Frame bits FRAME_W-3 (sign) and FRAME_W-4 (code MSB) carry the range indication. Both 1 means above positive full scale, both 0 means below negative full scale, and the two mixed values mean in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host, synchronous to clk |
| in_sign | input | 1 | Sign of the value the stand-in engine captures (1 = positive) |
| in_code | input | RES_W | Result code the engine captures on completion |
| in_sub | input | SUB_W | Sub-LSB bits the engine captures on completion |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (0 = high impedance) |

## Verification
The bench builds the block with RES_W = 6, SUB_W = 2 and CONV_CYCLES = 5, giving an 11-bit frame. At that size every sign and code combination (128 of them) can be read out bit by bit, with the expected frame formed arithmetically. A read can be aborted after every possible number of clocks, which exercises the restart path at every shift position. The short latency also lets the bench count each busy interval exactly: after reset, after an abort, after a complete read and after a chip-select pulse during conversion.

// File: rtl/ser_out_pkg.sv
// Package: shared state encoding for the serial result shifter.
// Assumes: nothing beyond IEEE 1800-2017.
package ser_out_pkg;

    // Shifter states: presenting live busy flag, shifting a frame, frame exhausted.
    typedef enum logic [1:0] {
        SH_LIVE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_DONE  = 2'd2
    } sh_state_e;

    // Number of status bits that lead every frame.
    localparam int STATUS_BITS = 3;

endpackage

// File: rtl/conv_engine.sv
// Module: conv_engine
// Stand-in conversion engine. A conversion runs for CONV_CYCLES clocks after
// reset or after a restart pulse. On completion, the engine captures the sign,
// code and sub-LSB inputs, drops busy, and then sleeps until the next restart.
// Assumes: restart is a single-cycle pulse synchronous to clk; CONV_CYCLES >= 1.
module conv_engine #(
    parameter int RES_W       = 24,
    parameter int SUB_W       = 5,
    parameter int CONV_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             in_sign,
    input  logic [RES_W-1:0] in_code,
    input  logic [SUB_W-1:0] in_sub,
    output logic             busy,
    output logic             res_sign,
    output logic [RES_W-1:0] res_code,
    output logic [SUB_W-1:0] res_sub
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Conversion timer: restart has priority; count while busy, finish at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (restart) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == LAST) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Result capture: take the inputs in the cycle the conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_sign <= 1'b0;
            res_code <= '0;
            res_sub  <= '0;
        end else if (!restart && busy && cnt_q == LAST) begin
            res_sign <= in_sign;
            res_code <= in_code;
            res_sub  <= in_sub;
        end
    end

endmodule

// File: rtl/sck_fall_det.sv
// Module: sck_fall_det
// Detects falling edges of the host serial clock, sampled on clk. SYNC_STAGES
// selects the variant: 0 uses sck directly (host synchronous to clk), and
// N > 0 inserts an N-flop synchroniser first, which adds N cycles of latency.
// Assumes: sck high and low phases each last at least one clk cycle.
module sck_fall_det #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic fall
);
    logic sck_s;
    logic sck_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign sck_s = sck;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;
            // Synchroniser chain: shift sck through SYNC_STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], sck} >> 0;
                end
            end
            assign sck_s = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    // Previous-sample register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_s;
        end
    end

    assign fall = sck_q & ~sck_s;

endmodule

// File: rtl/frame_shifter.sv
// Module: frame_shifter
// Output shift register and its control. While selected with no frame latched,
// it presents the live busy flag. It latches the frame once a result is ready,
// advances one bit per sck fall, and rests high after the last bit. A cs_n rise
// after a latch requests a new conversion.
// Assumes: cs_n synchronous to clk; frame_in is stable whenever busy is low.
module frame_shifter
    import ser_out_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck_fall,
    input  logic               busy,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sdo,
    output logic               restart,
    output sh_state_e          state,
    output logic [$clog2(FRAME_W)-1:0] bit_cnt
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    sh_state_e          state_q;
    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;

    // Abort or completion: deselect after a frame has been latched.
    assign restart = (state_q != SH_LIVE) && cs_n;

    // State, shift register and fall counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_LIVE;
            sreg_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SH_LIVE: begin
                    if (!cs_n && !busy) begin
                        state_q <= SH_SHIFT;
                        sreg_q  <= frame_in;
                        cnt_q   <= '0;
                    end
                end
                SH_SHIFT: begin
                    if (cs_n) begin
                        state_q <= SH_LIVE;
                    end else if (sck_fall) begin
                        if (cnt_q == LAST) begin
                            state_q <= SH_DONE;
                        end else begin
                            cnt_q  <= cnt_q + 1'b1;
                            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
                SH_DONE: begin
                    if (cs_n) begin
                        state_q <= SH_LIVE;
                    end
                end
                default: state_q <= SH_LIVE;
            endcase
        end
    end

    // Output select: live busy flag, current frame bit, or idle-high after the frame.
    always_comb begin
        case (state_q)
            SH_SHIFT: sdo = sreg_q[FRAME_W-1];
            SH_DONE:  sdo = 1'b1;
            default:  sdo = busy;
        endcase
    end

    assign state   = state_q;
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/ser_result_out.sv
// Module: ser_result_out (top)
// Serial result output stage. It joins the stand-in conversion engine, the
// serial-clock edge detector and the frame shifter. It builds the frame as
// {EOC=0, dummy=0, sign, code, sub} and drives the output enable from chip-select.
// Assumes: cs_n and sck synchronous to clk.
module ser_result_out
    import ser_out_pkg::*;
#(
    parameter int RES_W       = 24,
    parameter int SUB_W       = 5,
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             in_sign,
    input  logic [RES_W-1:0] in_code,
    input  logic [SUB_W-1:0] in_sub,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int FRAME_W = STATUS_BITS + RES_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    logic               conv_busy;
    logic               conv_restart;
    logic               res_sign;
    logic [RES_W-1:0]   res_code;
    logic [SUB_W-1:0]   res_sub;
    logic               sck_fall;
    logic [FRAME_W-1:0] frame;
    sh_state_e          sh_state;
    logic [CNT_W-1:0]   sh_cnt;

    conv_engine #(
        .RES_W      (RES_W),
        .SUB_W      (SUB_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (conv_restart),
        .in_sign (in_sign),
        .in_code (in_code),
        .in_sub  (in_sub),
        .busy    (conv_busy),
        .res_sign(res_sign),
        .res_code(res_code),
        .res_sub (res_sub)
    );

    sck_fall_det #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sck  (sck),
        .fall (sck_fall)
    );

    // Frame assembly: end-of-conversion low, dummy low, then the captured result.
    assign frame = {1'b0, 1'b0, res_sign, res_code, res_sub};

    frame_shifter #(
        .FRAME_W(FRAME_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck_fall(sck_fall),
        .busy    (conv_busy),
        .frame_in(frame),
        .sdo     (sdo),
        .restart (conv_restart),
        .state   (sh_state),
        .bit_cnt (sh_cnt)
    );

    assign sdo_oe = ~cs_n;

endmodule

// File: rtl/ser_result_out_chk.sv
// Module: ser_result_out_chk
// Property checker for ser_result_out, attached with bind below. It keeps its
// own busy-length counter so the conversion window needs no long $past.
module ser_result_out_chk
    import ser_out_pkg::*;
#(
    parameter int FRAME_W     = 32,
    parameter int CONV_CYCLES = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_n,
    input logic                       sdo,
    input logic                       busy,
    input logic                       restart,
    input sh_state_e                  sh_state,
    input logic [$clog2(FRAME_W)-1:0] sh_cnt
);
    localparam int CW = $clog2(CONV_CYCLES + 2) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] busy_len;

    // Independent busy-length counter, cleared by reset and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (restart) begin
            busy_len <= '0;
        end else if (busy && busy_len != CMAX) begin
            busy_len <= busy_len + 1'b1;
        end
    end

    AST_DUMMY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state == SH_SHIFT && sh_cnt == 1) |-> !sdo); // R1

    AST_LIVE_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state == SH_LIVE && !cs_n) |-> (sdo == busy)); // R3

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == CW'(CONV_CYCLES))); // R4

    AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state == SH_SHIFT && $past(sh_state) == SH_LIVE) |-> $past(!busy && !cs_n)); // R5

    AST_TAIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state == SH_DONE) |-> sdo); // R7

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && sh_state == SH_LIVE) |=> (sh_state == SH_LIVE)); // R8

    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state != SH_LIVE && cs_n) |=> (busy && sh_state == SH_LIVE)); // R9

endmodule

bind ser_result_out ser_result_out_chk #(
    .FRAME_W    (FRAME_W),
    .CONV_CYCLES(CONV_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sdo     (sdo),
    .busy    (conv_busy),
    .restart (conv_restart),
    .sh_state(sh_state),
    .sh_cnt  (sh_cnt)
);

// File: tb/sim_ser_result_out.sv
module sim_ser_result_out;
    localparam int RW = 6;
    localparam int SW = 2;
    localparam int CC = 5;
    localparam int FW = 3 + RW + SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          in_sign = 1'b0;
    logic [RW-1:0] in_code = '0;
    logic [SW-1:0] in_sub = '0;
    logic          sdo;
    logic          sdo_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ser_result_out #(
        .RES_W(RW), .SUB_W(SW), .CONV_CYCLES(CC), .SYNC_STAGES(0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .in_sign(in_sign), .in_code(in_code), .in_sub(in_sub),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [FW-1:0] frame_of(input logic s, input logic [RW-1:0] c,
                                              input logic [SW-1:0] u);
        return FW'(s) * (FW'(1) << (RW + SW)) + FW'(c) * (FW'(1) << SW) + FW'(u);
    endfunction

    // One sck pulse; returns just after the clock edge that sees the fall.
    task automatic sck_pulse();
        @(negedge clk) sck = 1'b1;
        @(negedge clk) sck = 1'b0;
        @(negedge clk);
        #1;
    endtask

    // Select, count cycles of live busy, then wait for the latch.
    task automatic begin_read(output int ones, input bit toggle);
        @(negedge clk) cs_n = 1'b0;
        #1;
        check("R2 oe on select", int'(sdo_oe), 1);
        ones = 0;
        for (int g = 0; g < 200 && sdo === 1'b1; g++) begin
            ones++;
            @(negedge clk);
            if (toggle) sck = ~sck;
            #1;
        end
        check("R3 live eoc low", int'(sdo), 0);
        sck = 1'b0;
        @(negedge clk);
        #1;
    endtask

    // Check latched frame over n falls (n = FW+1 means full read plus an extra edge).
    task automatic read_frame(input logic [FW-1:0] exp, input int n, input string tag);
        check(tag == "" ? "R5 first bit" : tag, int'(sdo), int'(exp[FW-1]));
        for (int k = 1; k <= n && k <= FW; k++) begin
            string t;
            sck_pulse();
            if (tag != "") t = tag;
            else if (k == 1) t = "R1 dummy";
            else if (k == 2 || k == 3) t = "R11 range bits";
            else if (k == FW) t = "R7 tail high";
            else t = "R6 shift bit";
            check(t, int'(sdo), k < FW ? int'(exp[FW-1-k]) : 1);
        end
        if (n > FW) begin
            sck_pulse();
            check("R7 stays high", int'(sdo), 1);
        end
    endtask

    task automatic end_read();
        @(negedge clk) cs_n = 1'b1;
        #1;
        check("R2 oe off", int'(sdo_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ones;
        logic [FW-1:0] fx;
        in_sign = 1'b1; in_code = 6'h3F; in_sub = 2'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 oe after reset", int'(sdo_oe), 0);

        // First conversion after reset, with sck toggling while busy (R8).
        begin_read(ones, 1'b1);
        check("R3 busy shown after reset", ones, CC - 1);
        read_frame(frame_of(1'b1, 6'h3F, 2'd3), FW + 1, "");
        end_read();

        // Exhaustive sign x code sweep, full reads.
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < (1 << RW); c++) begin
                in_sign = s[0];
                in_code = c[RW-1:0];
                in_sub  = SW'(c + s);
                begin_read(ones, 1'b0);
                check("R4 busy length", ones, CC);
                read_frame(frame_of(s[0], c[RW-1:0], SW'(c + s)), FW + 1, "");
                end_read();
            end
        end

        // Abort after every possible number of clocks.
        for (int k = 0; k < FW; k++) begin
            in_sign = k[0];
            in_code = RW'(k * 5);
            in_sub  = SW'(k);
            begin_read(ones, 1'b0);
            check("R9 restart after read", ones, CC);
            read_frame(frame_of(k[0], RW'(k * 5), SW'(k)), k, "R9 partial");
            end_read();
        end
        begin_read(ones, 1'b0);
        check("R9 restart after abort", ones, CC);
        read_frame(frame_of(1'b0, RW'((FW - 1) * 5), SW'(FW - 1)), FW + 1, "");
        in_sign = 1'b1; in_code = 6'h15; in_sub = 2'd1;
        end_read();

        // sck toggles while deselected are ignored.
        for (int t = 0; t < 10; t++) begin
            @(negedge clk) sck = 1'b1;
            #1;
            check("R2 oe stays off", int'(sdo_oe), 0);
            @(negedge clk) sck = 1'b0;
        end
        begin_read(ones, 1'b0);
        check("R8 ready already", ones, 0);
        read_frame(frame_of(1'b1, 6'h15, 2'd1), 3, "R8 start at top");
        end_read();

        // cs_n pulse during conversion does not restart.
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        begin_read(ones, 1'b0);
        check("R10 original schedule", ones, CC - 2);
        read_frame(frame_of(1'b1, 6'h15, 2'd1), FW + 1, "");

        // Capture at completion, later input changes ignored.
        fx = frame_of(1'b0, 6'h2A, 2'd2);
        in_sign = 1'b0; in_code = 6'h2A; in_sub = 2'd2;
        end_read();
        repeat (CC + 3) @(negedge clk);
        in_sign = 1'b1; in_code = 6'h01; in_sub = 2'd1;
        begin_read(ones, 1'b0);
        check("R4 no wait when ready", ones, 0);
        read_frame(fx, FW, "R4 captured value");
        end_read();

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule